// File: doc/BRIEF.md
# Sticky Interrupt Flag Aggregator

This block collects the interrupt sources of a serial controller into one 16-bit status word. A matching 16-bit enable word sits beside it, and the block drives a single level-sensitive interrupt line. The status word holds two kinds of flag.

Level flags are recomputed every cycle by comparing a FIFO fill count with a programmed threshold. Event flags capture one-cycle pulses from the FIFO and transaction logic. An event flag stays set until software writes a 1 to its bit. The interrupt line is high when any flag is both pending and enabled.

The FIFOs, the thresholds' storage and the serial engine sit outside this block. Their counts and threshold values arrive as plain inputs, and their events arrive as pulses on a vector whose bit positions match the status word. Software reaches both words through a simple write strobe with an address. The read data is a combinational function of the address.

Top module: `irq_flag_agg`

## Requirements
- R1: After reset the status word, the enable word and `irq` are all zero.
- R2: A one-cycle pulse on `ev_in[b]`, for an event bit b in {1 TX empty, 3 RX full, 11 transaction done, 12 TX overrun, 14 RX overrun, 15 RX underrun}, sets status bit b at that clock edge. The bit then stays set until it is cleared.
- R3: A write to offset 0x20 clears every event bit whose `wdata` bit is 1. Event bits whose `wdata` bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Status bit 0 equals (`tx_count` >= `tx_thresh`) and status bit 2 equals (`rx_count` >= `rx_thresh`), both sampled at each clock edge. A write of 1 to either bit does not clear it while its condition holds.
- R6: Status bits 4, 5, 8, 9, 13 and 31:16, and the same bits of the enable word, always read 0. This holds even after writes of all ones to both words and pulses on every `ev_in` bit. A pulse on `ev_in` at a level or unused position has no effect.
- R7: The enable word at offset 0x24 stores the written value of bits 0, 1, 2, 3, 11, 12, 14 and 15 and reads it back.
- R8: `irq` is a register that, after each clock edge, equals the OR over all bits of (status AND enable) as they stand after that same edge.
- R9: A write to any offset other than 0x20 or 0x24 changes nothing, and a read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_in | input | 16 | Event pulses, one per status bit position |
| tx_count | input | 6 | TX FIFO fill count |
| tx_thresh | input | 6 | TX level threshold |
| rx_count | input | 6 | RX FIFO fill count |
| rx_thresh | input | 6 | RX level threshold |
| irq | output | 1 | Interrupt request, level-sensitive |

## Verification
The hardest case to reach from the ports is a pulse and a clear that land on the same bit in the same cycle, since software writes and hardware events normally come from unrelated sources. The bench first sets two event bits. It then drives a pulse on one of them in the very cycle that a write of all ones to the status offset is active. It expects only the pulsed bit to survive. The other sweeps cover every pulse position, every (count, threshold) pair in a small range for both level flags, and every single-bit enable against every single pending event bit, so the aggregate interrupt is checked bit by bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      FK_NONE   = 2'd0,
      FK_EVENT  = 2'd1,
      FK_LVL_TX = 2'd2,
      FK_LVL_RX = 2'd3
   } flag_kind_e;

   // Position of each flag is fixed: software decodes these bit numbers.
   function automatic flag_kind_e kind_of(input int pos);
      case (pos)
         0:                     return FK_LVL_TX;
         2:                     return FK_LVL_RX;
         1, 3, 11, 12, 14, 15:  return FK_EVENT;
         default:               return FK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
   parameter int ADDR_W   = 8,
   parameter int STAT_OFS = 'h20,
   parameter int EN_OFS   = 'h24
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output logic              sel_stat,
   output logic              sel_en,
   output logic              stat_we,
   output logic              en_we
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

   generate
      if (STAT_OFS == EN_OFS) begin : g_bad_ofs
         $error("status and enable offsets must differ");
      end
      if (STAT_OFS >= (1 << ADDR_W) || EN_OFS >= (1 << ADDR_W)) begin : g_bad_range
         $error("register offsets exceed address width");
      end
   endgenerate

   always_comb begin
      sel_stat = (addr == STAT_A);
      sel_en   = (addr == EN_A);
      stat_we  = wr_en && sel_stat;
      en_we    = wr_en && sel_en;
   end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
   parameter irq_agg_pkg::flag_kind_e KIND = irq_agg_pkg::FK_NONE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_i,
   input  logic clr_i,
   input  logic lvl_i,
   input  logic en_we_i,
   input  logic en_wd_i,
   output logic stat_o,
   output logic stat_d_o,
   output logic en_o,
   output logic en_d_o
);
   import irq_agg_pkg::*;

   generate
      if (KIND == FK_NONE) begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, ev_i, clr_i, lvl_i, en_we_i, en_wd_i};
         assign stat_o   = 1'b0;
         assign stat_d_o = 1'b0;
         assign en_o     = 1'b0;
         assign en_d_o   = 1'b0;
      end else begin : g_live
         logic st_q, en_q;

         assign en_d_o = en_we_i ? en_wd_i : en_q;

         if (KIND == FK_EVENT) begin : g_evt
            logic unused_lvl;
            assign unused_lvl = lvl_i;
            // a pulse outranks a clear aimed at the same bit
            assign stat_d_o = ev_i | (st_q & ~clr_i);

            AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
               ev_i |=> st_q); // R2
            AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
               (st_q && !clr_i) |=> st_q); // R2
            AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_i && !ev_i) |=> !st_q); // R3
            AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
               (clr_i && ev_i) |=> st_q); // R4
         end else begin : g_lvl
            logic unused_evt;
            assign unused_evt = ev_i ^ clr_i;
            assign stat_d_o = lvl_i;

            AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> (st_q == $past(lvl_i))); // R5
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st_q <= 1'b0;
               en_q <= 1'b0;
            end else begin
               st_q <= stat_d_o;
               en_q <= en_d_o;
            end
         end

         assign stat_o = st_q;
         assign en_o   = en_q;
      end
   endgenerate
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int FLAG_W   = 16,
   parameter int CNT_W    = 6,
   parameter int STAT_OFS = 'h20,
   parameter int EN_OFS   = 'h24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [FLAG_W-1:0] ev_in,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  tx_thresh,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  rx_thresh,
   output logic              irq
);
   import irq_agg_pkg::*;

   localparam int PAD_W = DATA_W - FLAG_W;

   generate
      if (FLAG_W != 16) begin : g_bad_flag_w
         $error("flag layout is defined for 16 bits");
      end
      if (DATA_W <= FLAG_W) begin : g_bad_data_w
         $error("data width must exceed flag width");
      end
   endgenerate

   logic sel_stat, sel_en, stat_we, en_we;
   logic tx_ge, rx_ge;
   logic [FLAG_W-1:0] stat_q, stat_d, en_q, en_d;
   logic irq_q;
   logic unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:FLAG_W];

   irq_reg_decode #(
      .ADDR_W  (ADDR_W),
      .STAT_OFS(STAT_OFS),
      .EN_OFS  (EN_OFS)
   ) u_dec (
      .wr_en   (wr_en),
      .addr    (addr),
      .sel_stat(sel_stat),
      .sel_en  (sel_en),
      .stat_we (stat_we),
      .en_we   (en_we)
   );

   assign tx_ge = (tx_count >= tx_thresh);
   assign rx_ge = (rx_count >= rx_thresh);

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
         localparam flag_kind_e K = kind_of(i);
         irq_flag_cell #(.KIND(K)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_in[i]),
            .clr_i   (stat_we && wdata[i]),
            .lvl_i   ((K == FK_LVL_RX) ? rx_ge : tx_ge),
            .en_we_i (en_we),
            .en_wd_i (wdata[i]),
            .stat_o  (stat_q[i]),
            .stat_d_o(stat_d[i]),
            .en_o    (en_q[i]),
            .en_d_o  (en_d[i])
         );
      end
   endgenerate

   // registered from next-state values so irq lines up with the words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(stat_d & en_d);
   end
   assign irq = irq_q;

   always_comb begin
      if (sel_stat)    rdata = {{PAD_W{1'b0}}, stat_q};
      else if (sel_en) rdata = {{PAD_W{1'b0}}, en_q};
      else             rdata = '0;
   end

   AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(stat_q & en_q)); // R8
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[13] | stat_q[9] | stat_q[8] | stat_q[5] | stat_q[4]) == 1'b0); // R6
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we |=> $stable(en_q)); // R7
endmodule

// File: tb/irq_flag_agg_tb.sv
module irq_flag_agg_tb;
   localparam logic [15:0] EVT_MASK = 16'hD80A;
   localparam logic [15:0] IMP_MASK = 16'hD80F;
   localparam logic [7:0]  A_STAT = 8'h20;
   localparam logic [7:0]  A_EN   = 8'h24;
   localparam logic [7:0]  A_OTH  = 8'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] ev_in = '0;
   logic [5:0]  tx_count = 6'd0, tx_thresh = 6'd1, rx_count = 6'd0, rx_thresh = 6'd1;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   irq_flag_agg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ev_in(ev_in), .tx_count(tx_count), .tx_thresh(tx_thresh),
      .rx_count(rx_count), .rx_thresh(rx_thresh), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pulse(input logic [15:0] v);
      ev_in = v;
      tick();
      ev_in = '0;
   endtask

   initial begin
      logic [31:0] r;
      @(negedge clk);
      @(negedge clk);
      rd(A_STAT, r); chk("R1 status", r, 32'h0);
      rd(A_EN, r);   chk("R1 enable", r, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      tick();

      // R7 / R6: enable word keeps only implemented bits
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, r); chk("R7 enable all ones", r, {16'h0, IMP_MASK});
      wr(A_EN, 32'h0000_4802);
      rd(A_EN, r); chk("R7 enable pattern", r, 32'h0000_4802);
      wr(A_EN, 32'h0);

      // R2 / R3 / R6: every pulse position
      for (int b = 0; b < 16; b++) begin
         pulse(16'(1 << b));
         tick();
         rd(A_STAT, r); chk($sformatf("R2 pulse bit %0d", b), r, {16'h0, 16'(1 << b) & EVT_MASK});
         wr(A_STAT, 32'h0000_FFFF);
         rd(A_STAT, r); chk($sformatf("R3 clear bit %0d", b), r, 32'h0);
      end

      // R6: all pulses, all-ones write, reserved bits stay 0
      pulse(16'hFFFF);
      rd(A_STAT, r); chk("R6 all pulses", r, {16'h0, EVT_MASK});
      wr(A_STAT, 32'hFFFF_0000);
      rd(A_STAT, r); chk("R6 upper write", r, {16'h0, EVT_MASK});
      // R3 partial clear then zero write
      wr(A_STAT, 32'h0000_0802);
      rd(A_STAT, r); chk("R3 partial clear", r, {16'h0, EVT_MASK & ~16'h0802});
      wr(A_STAT, 32'h0);
      rd(A_STAT, r); chk("R3 zero write keeps", r, {16'h0, EVT_MASK & ~16'h0802});

      // R9: other offset
      wr(A_OTH, 32'hFFFF_FFFF);
      rd(A_STAT, r); chk("R9 stray write status", r, {16'h0, EVT_MASK & ~16'h0802});
      rd(A_EN, r);   chk("R9 stray write enable", r, 32'h0);
      rd(A_OTH, r);  chk("R9 stray read", r, 32'h0);
      wr(A_STAT, 32'h0000_FFFF);

      // R4: pulse and clear together
      pulse(16'h1002);
      ev_in = 16'h1000; wr_en = 1'b1; addr = A_STAT; wdata = 32'h0000_FFFF;
      tick();
      ev_in = '0; wr_en = 1'b0; wdata = '0;
      rd(A_STAT, r); chk("R4 event beats clear", r, 32'h0000_1000);
      wr(A_STAT, 32'h0000_FFFF);

      // R5: level sweeps
      for (int c = 0; c < 8; c++) begin
         for (int t = 0; t < 8; t++) begin
            tx_count = 6'(c); tx_thresh = 6'(t);
            rx_count = 6'(7 - c); rx_thresh = 6'(t);
            tick();
            rd(A_STAT, r);
            chk($sformatf("R5 level c=%0d t=%0d", c, t), r & 32'h5,
                {29'b0, (7 - c) >= t, 1'b0, c >= t});
         end
      end
      tx_count = 6'd5; tx_thresh = 6'd3; rx_count = 6'd9; rx_thresh = 6'd9;
      tick();
      wr(A_STAT, 32'h0000_0005);
      rd(A_STAT, r); chk("R5 write cannot clear level", r, 32'h0000_0005);
      tx_thresh = 6'd6; rx_thresh = 6'd10;
      tick();
      rd(A_STAT, r); chk("R5 level drops", r, 32'h0);

      // R8: every single-bit enable against every single pending event bit
      for (int s = 0; s < 16; s++) begin
         if (EVT_MASK[s]) begin
            pulse(16'(1 << s));
            for (int e = 0; e < 16; e++) begin
               wr(A_EN, 32'(1 << e));
               chk($sformatf("R8 irq stat=%0d en=%0d", s, e), {31'b0, irq}, {31'b0, s == e});
            end
            wr(A_STAT, 32'h0000_FFFF);
            chk($sformatf("R8 irq drops after clear %0d", s), {31'b0, irq}, 32'h0);
         end
      end
      // R8: level source with enable, irq updates on same edge
      wr(A_EN, 32'h0000_0004);
      rx_count = 6'd3; rx_thresh = 6'd2;
      tick();
      chk("R8 irq from level", {31'b0, irq}, 32'h1);
      rx_count = 6'd1;
      tick();
      chk("R8 irq level falls", {31'b0, irq}, 32'h0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule